// File: doc/BRIEF.md
# Wide Sticky Right Shifter

This block shifts a 128-bit operand right by an unsigned count. The operand arrives as two 64-bit words, a high one and a low one, and the result leaves in the same split. Zeros enter from the top. Any set bit that drops off the bottom is not lost: it is ORed into bit 0 of the result. A rounding stage further down therefore still knows that the value was inexact. It is typically used to align mantissas inside a fused multiply-add datapath.

Every count value is defined. Counts of 128 and above collapse the whole operand into a single sticky bit. Internally the shift is a logarithmic mux tree, with one stage for each count bit. Each stage OR-reduces the bits it discards. An optional output register, selected by a parameter and present by default, breaks the timing path.

Top module: `wide_sticky_shifter`

## Requirements
- R1: For a count from 1 to 63, bits 127..1 of the result equal the operand {hi,lo} logically shifted right by the count, with zeros filling from bit 127 down.
- R2: For a count from 1 to 127, result bit 0 is the shifted bit 0 ORed with the OR of all operand bits shifted below bit 0.
- R3: For a count of 128 to 255, the high result word is zero and the low result word is 1 if any operand bit is set, else 0.
- R4: For a count of 64 or more, the high result word is zero. For a count of exactly 64, the low result word equals the old high word with bit 0 ORed with (old low word nonzero).
- R5: A count of zero returns the operand unchanged.
- R6: A zero operand yields a zero result for every count. A nonzero operand never yields a zero result.
- R7: With the output register enabled (the default), the result for inputs present at one rising clock edge appears after that edge. Active-low asynchronous reset clears both result words to zero.
- R8: For a count from 65 to 127, the low result word is the old high word shifted right by (count-64), with the sticky OR on bit 0. Bits from the old low word contribute only through that sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_i | input | 64 | Operand bits 127..64 |
| lo_i | input | 64 | Operand bits 63..0 |
| count_i | input | 8 | Unsigned right-shift count |
| hi_o | output | 64 | Result bits 127..64 |
| lo_o | output | 64 | Result bits 63..0, with the sticky OR on bit 0 |

## Verification
The hardest cases sit right at the cut. The sticky bit must turn on when a single set bit lands one position below bit 0, and stay off when that bit lands exactly on bit 0. The same holds at the word boundary near a count of 64 and at saturation. The stimulus places a lone set bit at positions count-1 and count for every count from 1 to 127. It also sweeps all 256 counts over dense, sparse and random operands, so every stage of the mux tree and the saturation path is covered in both states.

// File: rtl/wss_pkg.sv
package wss_pkg;
  localparam int unsigned HALF_W_DEF = 64;
  localparam int unsigned CNT_W_DEF  = 8;
endpackage

// File: rtl/wss_shift_stage.sv
// One level of the log shifter: shift by SHIFT and fold discarded bits into sticky.
module wss_shift_stage #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned SHIFT  = 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  input  logic              sticky_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sticky_o
);
  logic lost;

  assign lost     = |data_i[SHIFT-1:0];
  assign data_o   = en_i ? (data_i >> SHIFT) : data_i;
  assign sticky_o = sticky_i | (en_i & lost);
endmodule

// File: rtl/wss_saturate.sv
// Merges sticky into bit 0, or collapses the whole operand when count >= DATA_W.
module wss_saturate #(
  parameter int unsigned DATA_W = 128
) (
  input  logic [DATA_W-1:0] orig_i,
  input  logic [DATA_W-1:0] shifted_i,
  input  logic              sticky_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    if (sat_i) begin
      data_o    = '0;
      data_o[0] = |orig_i;
    end else begin
      data_o    = shifted_i;
      data_o[0] = shifted_i[0] | sticky_i;
    end
  end
endmodule

// File: rtl/wss_out_reg.sv
module wss_out_reg #(
  parameter int unsigned DATA_W = 128,
  parameter bit          ENABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  if (ENABLE) begin : g_reg
    logic [DATA_W-1:0] q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_r <= '0;
      else         q_r <= d_i;
    end
    assign q_o = q_r;
  end else begin : g_wire
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/wide_sticky_shifter.sv
module wide_sticky_shifter
  import wss_pkg::*;
#(
  parameter int unsigned HALF_W  = HALF_W_DEF,
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] hi_i,
  input  logic [HALF_W-1:0] lo_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [HALF_W-1:0] hi_o,
  output logic [HALF_W-1:0] lo_o
);
  localparam int unsigned DATA_W = 2 * HALF_W;
  localparam int unsigned LVLS   = $clog2(DATA_W);

  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] lvl_data   [LVLS+1];
  logic              lvl_sticky [LVLS+1];
  logic              sat;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] result;

  assign operand       = {hi_i, lo_i};
  assign lvl_data[0]   = operand;
  assign lvl_sticky[0] = 1'b0;

  for (genvar k = 0; k < LVLS; k++) begin : g_lvl
    logic en;
    if (k < CNT_W) begin : g_bit
      assign en = count_i[k];
    end else begin : g_nobit
      assign en = 1'b0;
    end
    wss_shift_stage #(.DATA_W(DATA_W), .SHIFT(1 << k)) u_stage (
      .data_i   (lvl_data[k]),
      .en_i     (en),
      .sticky_i (lvl_sticky[k]),
      .data_o   (lvl_data[k+1]),
      .sticky_o (lvl_sticky[k+1])
    );
  end

  // counts past the tree's reach saturate
  if (CNT_W > LVLS) begin : g_sat
    assign sat = |count_i[CNT_W-1:LVLS];
  end else begin : g_nosat
    assign sat = 1'b0;
  end

  wss_saturate #(.DATA_W(DATA_W)) u_sat (
    .orig_i    (operand),
    .shifted_i (lvl_data[LVLS]),
    .sticky_i  (lvl_sticky[LVLS]),
    .sat_i     (sat),
    .data_o    (merged)
  );

  wss_out_reg #(.DATA_W(DATA_W), .ENABLE(OUT_REG)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (merged),
    .q_o    (result)
  );

  assign hi_o = result[DATA_W-1:HALF_W];
  assign lo_o = result[HALF_W-1:0];
endmodule

// File: rtl/wide_sticky_shifter_chk.sv
module wide_sticky_shifter_chk #(
  parameter int unsigned HALF_W  = 64,
  parameter int unsigned CNT_W   = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HALF_W-1:0] hi_i,
  input logic [HALF_W-1:0] lo_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [HALF_W-1:0] hi_o,
  input logic [HALF_W-1:0] lo_o
);
  localparam int unsigned DATA_W = 2 * HALF_W;

  logic [HALF_W-1:0] p_hi, p_lo;
  logic [CNT_W-1:0]  p_cnt;
  logic              ok;

  if (OUT_REG) begin : g_reg
    logic seen;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seen  <= 1'b0;
        p_hi  <= '0;
        p_lo  <= '0;
        p_cnt <= '0;
      end else begin
        seen  <= 1'b1;
        p_hi  <= hi_i;
        p_lo  <= lo_i;
        p_cnt <= count_i;
      end
    end
    assign ok = seen;
  end else begin : g_comb
    assign p_hi  = hi_i;
    assign p_lo  = lo_i;
    assign p_cnt = count_i;
    assign ok    = 1'b1;
  end

  AST_SAT_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && p_cnt >= CNT_W'(DATA_W)) |-> hi_o == '0); // R3
  AST_SAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && p_cnt >= CNT_W'(DATA_W)) |-> lo_o == {{(HALF_W-1){1'b0}}, |{p_hi, p_lo}}); // R3
  AST_WIDE_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && p_cnt >= CNT_W'(HALF_W)) |-> hi_o == '0); // R4
  AST_WORD_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && p_cnt == CNT_W'(HALF_W)) |-> lo_o == (p_hi | {{(HALF_W-1){1'b0}}, |p_lo})); // R4
  AST_HI_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && p_cnt < CNT_W'(HALF_W)) |-> hi_o == (p_hi >> p_cnt)); // R1
  AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && p_cnt == '0) |-> (hi_o == p_hi && lo_o == p_lo)); // R5
  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && {p_hi, p_lo} == '0) |-> {hi_o, lo_o} == '0); // R6
  AST_NONZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && {p_hi, p_lo} != '0) |-> {hi_o, lo_o} != '0); // R6
endmodule

bind wide_sticky_shifter wide_sticky_shifter_chk #(
  .HALF_W(HALF_W), .CNT_W(CNT_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hi_i(hi_i), .lo_i(lo_i),
  .count_i(count_i), .hi_o(hi_o), .lo_o(lo_o)
);

// File: tb/wide_sticky_shifter_test.sv
module wide_sticky_shifter_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] hi_i = '0, lo_i = '0;
  logic [7:0]  count_i = '0;
  logic [63:0] hi_o, lo_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [127:0] val;
    string        req;
    bit           do_r2;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  wide_sticky_shifter uut (
    .clk_i(clk), .rst_ni(rst_ni), .hi_i(hi_i), .lo_i(lo_i),
    .count_i(count_i), .hi_o(hi_o), .lo_o(lo_o)
  );

  function automatic logic [127:0] ref_shift(logic [127:0] v, int c);
    logic st = 1'b0;
    for (int i = 0; i < c; i++) begin
      st = st | v[0];
      v  = v >> 1;
    end
    v[0] = v[0] | st;
    return v;
  endfunction

  function automatic string req_of(logic [127:0] v, int c);
    if (v == '0)   return "R6";
    if (c == 0)    return "R5";
    if (c < 64)    return "R1";
    if (c == 64)   return "R4";
    if (c < 128)   return "R8";
    return "R3";
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // drive at negedge; the result of the previous vector is visible here
  task automatic step(logic [63:0] h, logic [63:0] l, int c, string tag);
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.req, {hi_o, lo_o}, e.val);
      if (e.do_r2) check("R2", {127'b0, lo_o[0]}, {127'b0, e.val[0]});
    end
    hi_i    = h;
    lo_i    = l;
    count_i = 8'(c);
    e.val   = ref_shift({h, l}, c);
    e.req   = (tag != "") ? tag : req_of({h, l}, c);
    e.do_r2 = (c >= 1 && c <= 127);
    q.push_back(e);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [127:0] v;
    hi_i = 64'hFFFF_0000_1234_5678;
    lo_i = 64'h0F0F_F0F0_AAAA_5555;
    count_i = 8'd3;
    repeat (3) @(negedge clk);
    check("R7", {hi_o, lo_o}, 128'b0);
    rst_ni = 1'b1;

    step(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0003, 1, "R7");
    step('0, '0, 0, "");
    step('0, '0, 200, "");
    step(64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEDC_BA98, 0, "");
    step(64'h1, 64'h0, 64, "");
    step(64'h2, 64'h5, 64, "");
    step(64'h0, 64'h1, 255, "R6");
    step(64'h0, 64'h0, 128, "");

    // lone bit at count-1 (sticky on) and at count (lands on bit 0)
    for (int c = 1; c < 128; c++) begin
      v = 128'b1 << (c - 1);
      step(v[127:64], v[63:0], c, "");
      v = 128'b1 << c;
      step(v[127:64], v[63:0], c, "");
    end

    for (int c = 0; c < 256; c++) begin
      step('1, '1, c, "");
      step(64'h8000_0000_0000_0000, 64'h0, c, "");
      step(64'h0, 64'h0000_0000_0000_0001, c, "");
      step(64'hAAAA_5555_AAAA_5555, 64'h3333_CCCC_3333_CCCC, c, "");
      step({$urandom, $urandom}, {$urandom, $urandom}, c, "");
    end

    for (int i = 0; i < 400; i++)
      step({$urandom, $urandom}, {$urandom, $urandom}, int'($urandom_range(0, 255)), "");

    step('0, '0, 0, "");
    @(negedge clk);
    finish_run();
  end
endmodule